// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Slave Address Filtering

This block receives asynchronous serial frames on one input line. A frame holds a start bit, eight data bits sent least significant bit first, an optional ninth bit and a stop bit. The line is oversampled at sixteen times the bit rate. The oversampling tick comes from one of two sources, and the receive mode chooses which. The data byte goes to a holding register. In the nine-bit modes the ninth bit goes to a companion flag. A receive flag then signals that a frame was accepted. A stop bit that samples low sets a sticky framing error flag.

In multiprocessor mode the receiver discards frames silently unless they carry a slave address that it recognises. There are two ways to match. The first is a masked comparison against a programmable address, where mask bits at 0 are don't-care. The second is a broadcast pattern formed as the OR of the address and the mask. When both registers are zero, every byte matches.

One host control position is shared by two functions. When the select input is 1, that position reads the framing error flag, and writing 0 to it clears the flag. When the select input is 0, the same position reads and writes the upper mode bit. The upper mode bit and the `mode_lo` input together choose the receive mode:

- upper bit 1, `mode_lo` 0: nine-bit mode, timed by the fixed tick.
- upper bit 1, `mode_lo` 1: nine-bit mode, timed by the timer tick.
- upper bit 0, `mode_lo` 1: eight-bit mode, timed by the timer tick.
- upper bit 0, `mode_lo` 0: the receiver is held idle.

Top module: `uart_rx_addr_filter`

## Requirements
- R1: After synchronous reset, `rx_data` is 0x00 and `rx_bit9`, `ri`, `fe` and `mode_hi` are all 0.
- R2: A falling edge on the synchronised `rxd`, seen while the receiver is idle, starts a frame and restarts the sixteen-step subdivision counter. If the start bit then reads as 1, the frame is dropped, and no flag or register changes.
- R3: Each bit value is the majority of three samples of the line, taken at subdivisions 7, 8 and 9 of the bit time. The data bits fill `rx_data` least significant bit first. In nine-bit mode, `rx_bit9` receives the ninth bit. In eight-bit mode, `rx_bit9` receives the stop bit.
- R4: Mode {`mode_hi`,`mode_lo`} = 10 counts `tick_fix`. Modes 11 and 01 count `tick_tmr`. Mode 00 holds the receiver idle, so `ri` never rises.
- R5: A stop bit that samples 0 sets `fe`, whether or not the frame is accepted. `fe` clears only on a `top_wr` with `fe_sel`=1 and `top_wdata`=0. Writing 1 leaves `fe` unchanged.
- R6: `top_rd` equals `fe` when `fe_sel`=1 and equals `mode_hi` when `fe_sel`=0. A `top_wr` with `fe_sel`=0 loads `mode_hi` from `top_wdata` and leaves `fe` alone. `mode_hi` changes only through such a write.
- R7: The given match is true when the byte equals `slv_addr` in every bit where `slv_mask` is 1. The broadcast match is true when the byte has a 1 in every bit where `slv_addr|slv_mask` is 1. As an example, with address 0xC0 and mask 0xFD, byte 0xC2 matches and byte 0xC1 does not.
- R8: With `mp_en`=1 in nine-bit mode, a frame is accepted only if its ninth bit is 1 and its byte matches (given or broadcast).
- R9: With `mp_en`=1 in eight-bit mode, a frame is accepted only if its stop bit is 1 and its byte matches.
- R10: With `mp_en`=0, every completed frame is accepted, including one with a bad stop bit. On acceptance, `rx_data` and `rx_bit9` load and `ri` sets. `ri` stays set until `ri_clr`. A rejected frame leaves `rx_data` unchanged.
- R11: With `slv_addr` and `slv_mask` both 0x00, every address frame matches, so filtering has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idles high |
| tick_fix | input | 1 | Oversampling tick from the fixed-rate source |
| tick_tmr | input | 1 | Oversampling tick from the timer source |
| mode_lo | input | 1 | Lower mode bit |
| mp_en | input | 1 | Multiprocessor address filter enable |
| slv_addr | input | DATA_W | Slave address |
| slv_mask | input | DATA_W | Slave address mask, 1 = compared bit |
| fe_sel | input | 1 | Shared control position selects framing error (1) or mode bit (0) |
| top_wr | input | 1 | Host write strobe for the shared position |
| top_wdata | input | 1 | Value written to the shared position |
| ri_clr | input | 1 | Host clear of the receive flag |
| rx_data | output | DATA_W | Received data byte |
| rx_bit9 | output | 1 | Ninth bit, or the stop bit in eight-bit mode |
| ri | output | 1 | Receive flag |
| fe | output | 1 | Framing error flag |
| mode_hi | output | 1 | Upper mode bit |
| top_rd | output | 1 | Read value of the shared position |

## Verification
The hardest case to reach is a frame whose start is recognised but whose clock source then stops. This happens when the timer tick is gated off while the receiver waits on it. The bench reaches it by running only the fixed tick in eight-bit mode, so the receiver is left stranded mid-frame. It then switches to the idle mode and checks that the receiver recovers with no flag raised. Address filtering is driven by vectors that pair one mask/address setting with bytes that hit the given pattern, hit the broadcast pattern, miss, or carry a cleared ninth bit. Glitch rejection is checked by sending a low pulse shorter than half a bit.

// File: rtl/uart_rxaf_pkg.sv
package uart_rxaf_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/rxaf_sync_edge.sv
module rxaf_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign dout = chain[STAGES-1];
  assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/rxaf_bit_sampler.sv
module rxaf_bit_sampler #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  input  logic din,
  output logic bit_strobe,
  output logic bit_val
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID_PT = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] EARLY  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LATE   = CNT_W'(OSR / 2 + 1);

  logic [CNT_W-1:0] cnt;
  logic s_early, s_mid;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt     <= '0;
      s_early <= 1'b1;
      s_mid   <= 1'b1;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
      if (cnt == EARLY)  s_early <= din;
      if (cnt == MID_PT) s_mid   <= din;
    end
  end

  // third sample is the live line value at the late point
  assign bit_strobe = tick && !restart && (cnt == LATE);
  assign bit_val    = (s_early & s_mid) | (s_early & din) | (s_mid & din);
endmodule

// File: rtl/rxaf_addr_match.sv
module rxaf_addr_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] rx_byte,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] mask,
  output logic         hit
);
  logic [W-1:0] bcast;
  logic given_hit, bcast_hit;

  assign bcast     = addr | mask;
  assign given_hit = ((rx_byte ^ addr) & mask) == '0;
  assign bcast_hit = (rx_byte & bcast) == bcast;
  assign hit       = given_hit | bcast_hit;
endmodule

// File: rtl/uart_rx_addr_filter.sv
module uart_rx_addr_filter
  import uart_rxaf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic              tick_fix,
  input  logic              tick_tmr,
  input  logic              mode_lo,
  input  logic              mp_en,
  input  logic [DATA_W-1:0] slv_addr,
  input  logic [DATA_W-1:0] slv_mask,
  input  logic              fe_sel,
  input  logic              top_wr,
  input  logic              top_wdata,
  input  logic              ri_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              ri,
  output logic              fe,
  output logic              mode_hi,
  output logic              top_rd
);
  localparam int BIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIDX_W-1:0] LAST_BIT = BIDX_W'(DATA_W - 1);

  rx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [BIDX_W-1:0] bidx;
  logic              ninth;
  logic              line, line_fall;
  logic              rx_en, tick_g, restart;
  logic              strobe, bval, hit, accept;

  assign rx_en   = mode_hi | mode_lo;
  assign tick_g  = rx_en & ((mode_hi & ~mode_lo) ? tick_fix : tick_tmr);
  assign restart = rx_en && (state == RX_IDLE) && line_fall;

  rxaf_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(rxd), .dout(line), .fall(line_fall)
  );

  rxaf_bit_sampler #(.OSR(OSR)) samp_i (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick_g), .din(line),
    .bit_strobe(strobe), .bit_val(bval)
  );

  rxaf_addr_match #(.W(DATA_W)) match_i (
    .rx_byte(shreg), .addr(slv_addr), .mask(slv_mask), .hit(hit)
  );

  // acceptance decided while the stop bit is being resolved
  always_comb begin
    if (!mp_en)       accept = 1'b1;
    else if (mode_hi) accept = ninth & hit;
    else              accept = bval & hit;
  end

  assign top_rd = fe_sel ? fe : mode_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      shreg   <= '0;
      bidx    <= '0;
      ninth   <= 1'b0;
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      ri      <= 1'b0;
      fe      <= 1'b0;
      mode_hi <= 1'b0;
    end else begin
      if (ri_clr) ri <= 1'b0;
      if (top_wr) begin
        if (fe_sel) begin
          if (!top_wdata) fe <= 1'b0;
        end else begin
          mode_hi <= top_wdata;
        end
      end

      if (!rx_en) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: if (line_fall) state <= RX_START;
          RX_START: if (strobe) begin
            bidx  <= '0;
            state <= bval ? RX_IDLE : RX_DATA;
          end
          RX_DATA: if (strobe) begin
            shreg <= {bval, shreg[DATA_W-1:1]};
            bidx  <= bidx + 1'b1;
            if (bidx == LAST_BIT) state <= mode_hi ? RX_NINTH : RX_STOP;
          end
          RX_NINTH: if (strobe) begin
            ninth <= bval;
            state <= RX_STOP;
          end
          RX_STOP: if (strobe) begin
            state <= RX_IDLE;
            if (!bval) fe <= 1'b1;
            if (accept) begin
              rx_data <= shreg;
              rx_bit9 <= mode_hi ? ninth : bval;
              ri      <= 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_lo,
  input logic              mp_en,
  input logic              fe_sel,
  input logic              top_wr,
  input logic              top_wdata,
  input logic              ri_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit9,
  input logic              ri,
  input logic              fe,
  input logic              mode_hi
);
  AST_FE_STICKY: assert property (@(posedge clk) disable iff (rst)
    fe && !(top_wr && fe_sel && !top_wdata) |=> fe); // R5

  AST_MODE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!top_wr || fe_sel) |=> $stable(mode_hi)); // R6

  AST_RI_HELD: assert property (@(posedge clk) disable iff (rst)
    ri && !ri_clr |=> ri); // R10

  AST_DATA_LOAD_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_data) |-> ri); // R10

  AST_IDLE_MODE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!mode_hi && !mode_lo) |=> !$rose(ri)); // R4

  AST_MP_NINTH_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(ri) && $past(mp_en && mode_hi) |-> rx_bit9); // R8
endmodule

bind uart_rx_addr_filter rxaf_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .mode_lo(mode_lo), .mp_en(mp_en), .fe_sel(fe_sel),
  .top_wr(top_wr), .top_wdata(top_wdata), .ri_clr(ri_clr), .rx_data(rx_data),
  .rx_bit9(rx_bit9), .ri(ri), .fe(fe), .mode_hi(mode_hi)
);

// File: tb/uart_rx_addr_filter_tb_top.sv
module uart_rx_addr_filter_tb_top;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  typedef struct packed {
    logic       hi, lo, src, mp;
    logic [7:0] addr, mask, dat;
    logic       b9, stop, eri, efe;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,8'hA5,1'b0,1'b1,1'b1,1'b0}, // R3 R10 nine-bit
    '{1'b1,1'b1,1'b0,1'b1,8'hC0,8'hFD,8'hC2,1'b1,1'b1,1'b1,1'b0}, // R7 R8 given hit
    '{1'b1,1'b1,1'b0,1'b1,8'hC0,8'hFD,8'hC1,1'b1,1'b1,1'b0,1'b0}, // R7 R8 miss
    '{1'b1,1'b1,1'b0,1'b1,8'hC0,8'hFD,8'hC2,1'b0,1'b1,1'b0,1'b0}, // R8 data frame
    '{1'b1,1'b1,1'b0,1'b1,8'hC0,8'hFD,8'hFF,1'b1,1'b1,1'b1,1'b0}, // R7 broadcast
    '{1'b1,1'b1,1'b0,1'b1,8'h00,8'h00,8'h37,1'b1,1'b1,1'b1,1'b0}, // R11
    '{1'b1,1'b0,1'b1,1'b0,8'h00,8'h00,8'h3C,1'b1,1'b1,1'b1,1'b0}, // R4 fixed tick
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,8'h5A,1'b0,1'b1,1'b1,1'b0}, // R3 eight-bit
    '{1'b0,1'b1,1'b0,1'b1,8'hC0,8'hFD,8'hC2,1'b0,1'b1,1'b1,1'b0}, // R9 hit
    '{1'b0,1'b1,1'b0,1'b1,8'hC0,8'hFD,8'hC2,1'b0,1'b0,1'b0,1'b1}, // R9 R5 bad stop
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,8'h81,1'b0,1'b0,1'b1,1'b1}, // R10 R5
    '{1'b0,1'b1,1'b1,1'b0,8'h00,8'h00,8'h99,1'b0,1'b1,1'b0,1'b0}, // R4 wrong source
    '{1'b0,1'b0,1'b1,1'b0,8'h00,8'h00,8'h66,1'b0,1'b1,1'b0,1'b0}  // R4 idle mode
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd = 1'b1;
  logic tick_fix = 1'b0, tick_tmr = 1'b0;
  logic mode_lo = 1'b0, mp_en = 1'b0;
  logic [7:0] slv_addr = '0, slv_mask = '0;
  logic fe_sel = 1'b0, top_wr = 1'b0, top_wdata = 1'b0, ri_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit9, ri, fe, mode_hi, top_rd;

  logic fix_on = 1'b0, tmr_on = 1'b1;
  int   tdiv = 0;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  uart_rx_addr_filter dut_i (
    .clk(clk), .rst(rst), .rxd(rxd), .tick_fix(tick_fix), .tick_tmr(tick_tmr),
    .mode_lo(mode_lo), .mp_en(mp_en), .slv_addr(slv_addr), .slv_mask(slv_mask),
    .fe_sel(fe_sel), .top_wr(top_wr), .top_wdata(top_wdata), .ri_clr(ri_clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .ri(ri), .fe(fe), .mode_hi(mode_hi),
    .top_rd(top_rd)
  );

  initial forever begin
    @(negedge clk);
    tdiv     = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    tick_tmr = tmr_on && (tdiv == 0);
    tick_fix = fix_on && (tdiv == 0);
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic val);
    @(negedge clk);
    fe_sel = sel; top_wr = 1'b1; top_wdata = val;
    @(negedge clk);
    top_wr = 1'b0;
  endtask

  task automatic clear_ri();
    @(negedge clk); ri_clr = 1'b1;
    @(negedge clk); ri_clr = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop, input logic nine);
    @(negedge clk);
    rxd = 1'b0; repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i]; repeat (BITC) @(negedge clk);
    end
    if (nine) begin
      rxd = b9; repeat (BITC) @(negedge clk);
    end
    rxd = stop; repeat (BITC) @(negedge clk);
    rxd = 1'b1; repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (1000 * 200) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rx_data", 16'(rx_data), 16'h00);
    check("R1 flags", 16'({rx_bit9, ri, fe, mode_hi}), 16'h0);

    for (int v = 0; v < NV; v++) begin
      fix_on = VECS[v].src; tmr_on = !VECS[v].src;
      @(negedge clk);
      mode_lo  = VECS[v].lo;
      mp_en    = VECS[v].mp;
      slv_addr = VECS[v].addr;
      slv_mask = VECS[v].mask;
      host_write(1'b0, VECS[v].hi);
      clear_ri();
      host_write(1'b1, 1'b0);
      prev = rx_data;
      send_frame(VECS[v].dat, VECS[v].b9, VECS[v].stop, VECS[v].hi);
      check($sformatf("R8/R9/R10 ri vec%0d", v), 16'(ri), 16'(VECS[v].eri));
      check($sformatf("R5 fe vec%0d", v), 16'(fe), 16'(VECS[v].efe));
      if (VECS[v].eri) begin
        check($sformatf("R3 data vec%0d", v), 16'(rx_data), 16'(VECS[v].dat));
        check($sformatf("R3 bit9 vec%0d", v), 16'(rx_bit9),
              16'(VECS[v].hi ? VECS[v].b9 : VECS[v].stop));
      end else begin
        check($sformatf("R10 data kept vec%0d", v), 16'(rx_data), 16'(prev));
      end
    end

    // R1 reset after activity
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 rx_data after reset", 16'(rx_data), 16'h00);
    check("R1 flags after reset", 16'({rx_bit9, ri, fe, mode_hi}), 16'h0);

    // R2 short low glitch is rejected, then a real frame is received
    fix_on = 1'b0; tmr_on = 1'b1; mode_lo = 1'b1; mp_en = 1'b0;
    @(negedge clk); rxd = 1'b0;
    repeat (3 * TDIV) @(negedge clk); rxd = 1'b1;
    repeat (12 * BITC) @(negedge clk);
    check("R2 glitch ri", 16'(ri), 16'h0);
    check("R2 glitch data", 16'(rx_data), 16'h00);
    send_frame(8'h42, 1'b0, 1'b1, 1'b0);
    check("R2 frame after glitch", 16'({ri, rx_data}), 16'h142);

    // R5 R6 shared control position
    send_frame(8'h18, 1'b0, 1'b0, 1'b0);
    check("R5 fe set", 16'(fe), 16'h1);
    fe_sel = 1'b1; @(negedge clk);
    check("R6 read fe", 16'(top_rd), 16'h1);
    host_write(1'b1, 1'b1);
    check("R5 write one keeps fe", 16'(fe), 16'h1);
    host_write(1'b0, 1'b1);
    check("R6 mode write leaves fe", 16'({mode_hi, fe}), 16'h3);
    fe_sel = 1'b0; @(negedge clk);
    check("R6 read mode", 16'(top_rd), 16'h1);
    host_write(1'b1, 1'b0);
    check("R5 fe cleared", 16'({mode_hi, fe}), 16'h2);
    clear_ri();
    check("R10 ri cleared", 16'(ri), 16'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule